// File: doc/BRIEF.md
# Lane-Rotating Virtual Channel Allocator

This block picks the virtual channel (VC) that each arriving flit is written into, in an input-buffered router where the VCs of all input ports share one pool. Every input port has a home group of VCs, and each group feeds one crossbar input lane. The allocator may place a packet in another port's group. The packet then crosses the crossbar on that port's lane, but it keeps its own input port, output port and route. A rotation counter shifts the starting VC for each new packet, so the traffic of a busy port is spread over all lanes and no single lane carries most of the switching.

A head flit opens a packet and gets a VC. Body and tail flits reuse that VC, and the tail releases it. A mode input selects between fixed home mapping and rotating mapping. The VC that is chosen, and the lane it implies, are reported one cycle after the flit is accepted. The buffers and the switch allocator use this report as the write index and the crossbar input. When no VC is available for a head flit, the port is held off until one frees up.

Top module: `lane_rot_vc_alloc`

## Requirements
- R1: After synchronous reset no grant is reported, no VC is held, no packet is open, and the rotation counter is zero.
- R2: With `rotate_en_i` low, a head flit on port p starts its search at VC p*VPP, the first VC of its home group. The rotation counter does not change in this mode.
- R3: With `rotate_en_i` high, a head flit on port p starts its search at VC (p*VPP + cnt) mod NVC. The counter cnt starts at zero and, in this mode, advances by the number of head flits granted in each cycle.
- R4: A VC is available when `vc_free_i` is 1 for it and no open packet holds it. The head flit gets the first available VC found by stepping upward from the start VC and wrapping from NVC-1 to 0.
- R5: When no VC is available for a head flit, `flit_ready_o` for that port is 0, nothing is granted, and the flit stays at the input. Non-head flits of an open packet are always accepted.
- R6: When several ports present head flits in one cycle, ports are served in index order, lowest first. A higher port never receives a VC that a lower port took in the same cycle.
- R7: Body and tail flits are granted the VC that the head of their packet received.
- R8: A head flit without the tail flag holds its VC until the tail of that packet is accepted. A flit with both head and tail flags holds nothing. A released VC becomes available in the cycle after the tail is accepted.
- R9: One cycle after a flit is accepted, `grant_valid_o` for its port is 1 and `grant_vc_o` gives the VC. `grant_lane_o` gives the lane, which is the VC index divided by VPP.
- R10: In rotating mode, with all VCs free and a steady stream of single-flit packets, the number of grants on each crossbar lane is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rotate_en_i | input | 1 | 1 selects rotating mapping, 0 selects fixed home mapping |
| flit_valid_i | input | NP | A flit is present on each port |
| flit_head_i | input | NP | The flit opens a packet |
| flit_tail_i | input | NP | The flit closes a packet |
| vc_free_i | input | NVC | The VC buffer can accept a new packet |
| flit_ready_o | output | NP | The flit on the port is accepted this cycle |
| grant_valid_o | output | NP | A grant from the previous cycle is reported |
| grant_vc_o | output | NP x VCW | VC that the flit is written into |
| grant_lane_o | output | NP x LW | Crossbar input lane of that VC |

## Verification
A wrong hold bit shows up in the same cycle as a lost or dropped backpressure on `flit_ready_o`. One cycle later it shows as a second packet granted into a VC that is still open. A rotation counter that is off by one changes the VC of the next head grant, so the error is visible on `grant_vc_o` one cycle after that head is accepted. A port tracker that loses its VC sends body flits to another VC, and the reported VC differs from the head's VC within a packet. A long run of uniform single-flit traffic then shows any bias in the rotation as unequal lane counts.

// File: rtl/lrva_pkg.sv
package lrva_pkg;
  // Index reached by stepping k places upward from start, wrapping at n.
  function automatic int unsigned cyc_idx(input int unsigned start,
                                          input int unsigned k,
                                          input int unsigned n);
    return (start + k) % n;
  endfunction
endpackage

// File: rtl/lrva_pick.sv
module lrva_pick #(
  parameter int NVC = 4,
  parameter int VCW = 2
) (
  input  logic [NVC-1:0] avail_i,
  input  logic [VCW-1:0] start_i,
  output logic           found_o,
  output logic [VCW-1:0] idx_o
);
  import lrva_pkg::*;

  always_comb begin
    found_o = 1'b0;
    idx_o   = start_i;
    for (int k = 0; k < NVC; k++) begin
      int unsigned c;
      c = cyc_idx(int'(start_i), k, NVC);
      if (!found_o && avail_i[c]) begin
        found_o = 1'b1;
        idx_o   = VCW'(c);
      end
    end
  end
endmodule

// File: rtl/lrva_rot_ctr.sv
module lrva_rot_ctr #(
  parameter int NP  = 2,
  parameter int NVC = 4,
  parameter int VCW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic [NP-1:0]  hd_take_i,
  output logic [VCW-1:0] cnt_o
);
  logic [VCW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (en_i)
      cnt_q <= VCW'((int'(cnt_q) + $countones(hd_take_i)) % NVC);
  end

  assign cnt_o = cnt_q;

  assert_ctr_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/lrva_port_trk.sv
module lrva_port_trk #(
  parameter int VCW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           take_head_i,
  input  logic           take_body_i,
  input  logic           tail_i,
  input  logic [VCW-1:0] new_vc_i,
  output logic           active_o,
  output logic [VCW-1:0] cur_vc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      cur_vc_o <= '0;
    end else if (take_head_i) begin
      active_o <= ~tail_i;
      cur_vc_o <= new_vc_i;
    end else if (take_body_i && tail_i) begin
      active_o <= 1'b0;
    end
  end

  assert_vc_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (active_o && !take_head_i) |=> $stable(cur_vc_o));
endmodule

// File: rtl/lane_rot_vc_alloc.sv
module lane_rot_vc_alloc #(
  parameter int NP  = 2,
  parameter int VPP = 2,
  localparam int NVC = NP * VPP,
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int LW  = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rotate_en_i,
  input  logic [NP-1:0]          flit_valid_i,
  input  logic [NP-1:0]          flit_head_i,
  input  logic [NP-1:0]          flit_tail_i,
  input  logic [NVC-1:0]         vc_free_i,
  output logic [NP-1:0]          flit_ready_o,
  output logic [NP-1:0]          grant_valid_o,
  output logic [NP-1:0][VCW-1:0] grant_vc_o,
  output logic [NP-1:0][LW-1:0]  grant_lane_o
);
  logic [NVC-1:0]         held_q;
  logic [NVC-1:0]         mask [NP+1];
  logic [VCW-1:0]         cnt;
  logic [NP-1:0]          found;
  logic [NP-1:0]          hd_take;
  logic [NP-1:0]          bd_take;
  logic [NP-1:0]          active;
  logic [NP-1:0][VCW-1:0] pick;
  logic [NP-1:0][VCW-1:0] start;
  logic [NP-1:0][VCW-1:0] cur_vc;

  assign mask[0] = vc_free_i & ~held_q;

  lrva_rot_ctr #(.NP(NP), .NVC(NVC), .VCW(VCW)) u_ctr (
    .clk(clk), .rst(rst), .en_i(rotate_en_i),
    .hd_take_i(hd_take), .cnt_o(cnt)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int HOME = p * VPP;

    assign start[p] = rotate_en_i ? VCW'((HOME + int'(cnt)) % NVC) : VCW'(HOME);

    lrva_pick #(.NVC(NVC), .VCW(VCW)) u_pick (
      .avail_i(mask[p]), .start_i(start[p]),
      .found_o(found[p]), .idx_o(pick[p])
    );

    assign hd_take[p] = flit_valid_i[p] & flit_head_i[p] & found[p];
    assign bd_take[p] = flit_valid_i[p] & ~flit_head_i[p] & active[p];
    assign flit_ready_o[p] = ~flit_head_i[p] | found[p];
    assign mask[p+1] = hd_take[p] ? (mask[p] & ~(NVC'(1) << pick[p])) : mask[p];

    lrva_port_trk #(.VCW(VCW)) u_trk (
      .clk(clk), .rst(rst),
      .take_head_i(hd_take[p]), .take_body_i(bd_take[p]),
      .tail_i(flit_tail_i[p]), .new_vc_i(pick[p]),
      .active_o(active[p]), .cur_vc_o(cur_vc[p])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        grant_valid_o[p] <= 1'b0;
        grant_vc_o[p]    <= '0;
        grant_lane_o[p]  <= '0;
      end else begin
        grant_valid_o[p] <= hd_take[p] | bd_take[p];
        if (hd_take[p]) begin
          grant_vc_o[p]   <= pick[p];
          grant_lane_o[p] <= LW'(int'(pick[p]) / VPP);
        end else if (bd_take[p]) begin
          grant_vc_o[p]   <= cur_vc[p];
          grant_lane_o[p] <= LW'(int'(cur_vc[p]) / VPP);
        end
      end
    end

    assert_head_only_stall_R5: assert property (@(posedge clk) disable iff (rst)
      (flit_valid_i[p] && !flit_ready_o[p]) |-> flit_head_i[p]);

    assert_no_double_hold_R8: assert property (@(posedge clk) disable iff (rst)
      hd_take[p] |-> !held_q[pick[p]]);

    assert_grant_report_R9: assert property (@(posedge clk) disable iff (rst)
      hd_take[p] |=> (grant_valid_o[p] && grant_vc_o[p] == $past(pick[p])));

    for (genvar q = p + 1; q < NP; q++) begin : g_pair
      assert_distinct_vc_R6: assert property (@(posedge clk) disable iff (rst)
        (hd_take[p] && hd_take[q]) |-> (pick[p] != pick[q]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (bd_take[p] && flit_tail_i[p]) held_q[cur_vc[p]] <= 1'b0;
        if (hd_take[p] && !flit_tail_i[p]) held_q[pick[p]] <= 1'b1;
      end
    end
  end
endmodule

// File: tb/test_lane_rot_vc_alloc.sv
module test_lane_rot_vc_alloc;
  localparam int NP = 2;
  localparam int VPP = 2;
  localparam int NVC = 4;

  localparam bit [2:0] NONE = 3'b000, HEAD = 3'b110, HT = 3'b111,
                       BODY = 3'b100, TAIL = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rotate_en_i = 1'b0;
  logic [NP-1:0] flit_valid_i = '0, flit_head_i = '0, flit_tail_i = '0;
  logic [NVC-1:0] vc_free_i = '1;
  logic [NP-1:0] flit_ready_o, grant_valid_o;
  logic [NP-1:0][1:0] grant_vc_o;
  logic [NP-1:0][0:0] grant_lane_o;

  lane_rot_vc_alloc #(.NP(NP), .VPP(VPP)) i_lane_rot_vc_alloc (.*);

  always #5 clk = ~clk;

  int nvec = 0, nbad = 0;
  bit done = 0;
  int exp_q[$];
  int last_vc[NP];
  int lane_cnt[NP];
  // bench model state
  bit [NVC-1:0] m_held;
  int m_cnt;
  bit m_act[NP];
  int m_cur[NP];
  string tag;

  task automatic chk(input int act, input int expv, input string req);
    nvec++;
    if (act != expv) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; flit_valid_i = '0; flit_head_i = '0; flit_tail_i = '0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_held = '0; m_cnt = 0; exp_q.delete();
    for (int p = 0; p < NP; p++) begin m_act[p] = 0; m_cur[p] = 0; end
    chk(int'(grant_valid_o), 0, "R1 no grant after reset");
  endtask

  // One cycle of stimulus; the model predicts readiness and grants.
  task automatic step(input bit [2:0] f0, input bit [2:0] f1,
                      input bit [NVC-1:0] free, input bit rot, input string req);
    bit [2:0] f[NP];
    bit [NVC-1:0] av;
    bit hd[NP], gv[NP];
    int gvc[NP];
    f[0] = f0; f[1] = f1;
    @(negedge clk);
    tag = req;
    rotate_en_i = rot; vc_free_i = free;
    for (int p = 0; p < NP; p++) begin
      flit_valid_i[p] = f[p][2]; flit_head_i[p] = f[p][1]; flit_tail_i[p] = f[p][0];
    end
    #1;
    av = free & ~m_held;
    for (int p = 0; p < NP; p++) begin
      bit rdy;
      rdy = 1; hd[p] = 0; gv[p] = 0; gvc[p] = 0;
      if (f[p][2] && f[p][1]) begin
        int s;
        bit fnd;
        s = rot ? (p * VPP + m_cnt) % NVC : p * VPP;
        fnd = 0;
        for (int k = 0; k < NVC; k++) begin
          int c;
          c = (s + k) % NVC;
          if (!fnd && av[c]) begin fnd = 1; gvc[p] = c; end
        end
        rdy = fnd;
        if (fnd) begin av[gvc[p]] = 0; hd[p] = 1; gv[p] = 1; end
      end else if (f[p][2] && m_act[p]) begin
        gv[p] = 1; gvc[p] = m_cur[p];
      end
      if (f[p][2]) chk(int'(flit_ready_o[p]), int'(rdy), {req, " ready (R5)"});
      if (gv[p]) exp_q.push_back(p * 16 + gvc[p]);
    end
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      if (gv[p] && !hd[p] && f[p][0]) begin m_held[gvc[p]] = 0; m_act[p] = 0; end
    end
    for (int p = 0; p < NP; p++) begin
      if (hd[p]) begin
        if (!f[p][0]) m_held[gvc[p]] = 1;
        m_act[p] = !f[p][0]; m_cur[p] = gvc[p];
        if (rot) m_cnt = (m_cnt + 1) % NVC;
      end
    end
    #1;
    // monitor: pop expected grants and compare
    for (int p = 0; p < NP; p++) begin
      if (grant_valid_o[p]) begin
        if (exp_q.size() == 0) begin
          chk(p * 16 + int'(grant_vc_o[p]), -1, {req, " unexpected grant (R9)"});
        end else begin
          chk(p * 16 + int'(grant_vc_o[p]), exp_q.pop_front(), {req, " grant vc (R7/R9)"});
        end
        chk(int'(grant_lane_o[p]), int'(grant_vc_o[p]) / VPP, {req, " lane (R9)"});
        last_vc[p] = int'(grant_vc_o[p]);
        lane_cnt[grant_lane_o[p]]++;
      end
    end
    if (exp_q.size() != 0) begin
      chk(exp_q.size(), 0, {req, " missing grant (R9)"});
      exp_q.delete();
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin @(posedge clk); cyc++; end
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 / R2: fixed mapping, home groups
    step(HEAD, HEAD, 4'hF, 0, "R2 fixed heads");
    chk(last_vc[0], 0, "R2 port0 home");
    chk(last_vc[1], 2, "R2 port1 home");
    step(BODY, TAIL, 4'hF, 0, "R7 body/tail");
    chk(last_vc[0], 0, "R7 body keeps vc");
    chk(last_vc[1], 2, "R7 tail keeps vc");
    step(TAIL, NONE, 4'hF, 0, "R7 tail");
    // R4: busy target, forward search
    step(HT, NONE, 4'b1110, 0, "R4 search");
    chk(last_vc[0], 1, "R4 next free vc");
    step(NONE, HT, 4'b0011, 0, "R4 wrap");
    chk(last_vc[1], 0, "R4 wraparound");
    // R5: no VC available
    step(HEAD, NONE, 4'h0, 0, "R5 none free");
    chk(int'(grant_valid_o[0]), 0, "R5 no grant when blocked");
    // R8: hold until tail, released next cycle
    step(HEAD, NONE, 4'b0001, 0, "R8 open on vc0");
    step(TAIL, HEAD, 4'b0001, 0, "R8 release same cycle");
    chk(int'(grant_valid_o[1]), 0, "R8 vc0 still held");
    step(NONE, HT, 4'b0001, 0, "R8 reuse");
    chk(last_vc[1], 0, "R8 vc0 reused");
    // R6: contention
    step(HT, HT, 4'b0100, 1, "R6 contention");
    chk(last_vc[0], 2, "R6 low port wins");
    chk(int'(grant_valid_o[1]), 0, "R6 high port held off");
    // R3: rotation from a fresh counter
    do_reset();
    for (int i = 0; i < NVC; i++) begin
      step(HT, NONE, 4'hF, 1, "R3 rotate");
      chk(last_vc[0], i, "R3 rotating start");
    end
    // R10: lane balance under uniform traffic
    for (int p = 0; p < NP; p++) lane_cnt[p] = 0;
    for (int i = 0; i < 40; i++) step(HT, NONE, 4'hF, 1, "R10 single port");
    chk(lane_cnt[0], lane_cnt[1], "R10 lane balance one port");
    for (int p = 0; p < NP; p++) lane_cnt[p] = 0;
    for (int i = 0; i < 40; i++) step(HT, HT, 4'hF, 1, "R10 both ports");
    chk(lane_cnt[0], lane_cnt[1], "R10 lane balance two ports");
    // mixed traffic against the model
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      bit [2:0] f[NP];
      bit [NVC-1:0] fr;
      for (int p = 0; p < NP; p++) begin
        bit v, t;
        v = ($urandom % 4) != 0;
        t = ($urandom % 3) == 0;
        f[p] = !v ? NONE : (!m_act[p] ? {2'b11, t} : {2'b10, t});
      end
      fr = 4'(($urandom % 5 == 0) ? $urandom : 4'hF);
      step(f[0], f[1], fr, 1'($urandom % 2), "R4/R6/R8 mixed");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule